// File: doc/BRIEF.md
# Global 64-bit Counter Timer with Auto-Increment Comparator

This block is a memory-mapped system timer. A 64-bit free-running counter advances by one each clock while its start bit is set. Software reaches the counter through two 32-bit halves that can be read on their own. The usual way to read it safely is upper, lower, upper, repeating the sequence if the two upper reads disagree. A 64-bit comparator watches the counter and raises a sticky match status, and an enable bit gates that status onto a level interrupt. In auto-increment mode each match adds a 32-bit step to the comparator, which produces a periodic event stream from a single compare.

Writes to the counter halves, the comparator halves, the step register and the control register pass through a fixed synchronisation delay before they take effect. When each one lands, it sets its own sticky write-confirmation bit. Software polls for that bit and then clears it by writing 1 to it. Writes to the interrupt-enable, interrupt-status and write-confirmation registers act on the next clock edge.

Top module: `gcnt_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `irq_o` is low.
- R2: The counter rises by exactly one per clock while control bit 8 (start) is set, and holds its value while that bit is clear.
- R3: A write to counter-low (offset 0x00) or counter-high (offset 0x04) replaces only that half. It becomes visible 3 clocks after the write edge, in the same cycle as bit 0 (low) or bit 1 (high) of the counter confirmation register (offset 0x24). Neither is visible after 2 clocks.
- R4: Writes to comparator-low (0x08), comparator-high (0x0C), step (0x10) and control (0x14) also land 3 clocks after the write edge. Each sets a bit in the confirmation register at 0x20: bit 0 for comparator-low, bit 1 for comparator-high, bit 2 for step, bit 16 for control. Control keeps only bits 0, 1 and 8 and reads the others as 0.
- R5: A confirmation bit stays set until a 1 is written to its position. Writing 0 there leaves it set.
- R6: When comparator enable (control bit 0) is set and the counter equals all 64 comparator bits, bit 0 of the match status register (0x1C) sets and stays set.
- R7: `irq_o` is high exactly when match status bit 0 and bit 0 of the interrupt-enable register (0x18) are both 1. The enable takes effect on the next edge.
- R8: Writing 1 to bit 0 of 0x1C clears the match status, unless a match occurs in that same cycle, in which case the status stays set.
- R9: With auto-increment (control bit 1) set, each match adds the step register to the comparator, so matches recur every step-count clocks while the counter runs.
- R10: With comparator enable clear, an equal counter and comparator never set the match status.
- R11: The halves are read independently while the counter runs, and the low half carries into the high half when it wraps from 0xFFFFFFFF.
- R12: A match requires all 64 bits to agree. Equal low halves with different high halves do not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt: match status AND enable |

## Verification
A vector table sends one write to each delayed register. For each write it checks the confirmation bit two clocks later, while it must still be clear, and again three clocks later, when it must be set together with the new register value. This separates a correct delay from one that is too short or too long, and it also shows whether the right confirmation bit was picked. The comparator is then tried against a stopped counter in four cases: equal with enable off, equal on the low half only, fully equal, and fully equal while a clear is written. These cases separate the enable gate, the width of the compare and the set-over-clear priority. A running counter started below a low-half wrap checks the carry, and a run with a step of 7 checks the auto-increment arithmetic against a closed-form expected comparator value.

// File: rtl/gcnt_pkg.sv
// Shared definitions for the global counter timer: register offsets,
// control bit positions and the encoding of delayed-write targets.
package gcnt_pkg;

    localparam int OFF_CNT_LO  = 6'h00;
    localparam int OFF_CNT_HI  = 6'h04;
    localparam int OFF_CMP_LO  = 6'h08;
    localparam int OFF_CMP_HI  = 6'h0C;
    localparam int OFF_STEP    = 6'h10;
    localparam int OFF_CTRL    = 6'h14;
    localparam int OFF_IEN     = 6'h18;
    localparam int OFF_ISTAT   = 6'h1C;
    localparam int OFF_WCONF   = 6'h20;
    localparam int OFF_CWCONF  = 6'h24;

    // Control bit positions
    localparam int CTRL_CMP_EN = 0;
    localparam int CTRL_AUTO   = 1;
    localparam int CTRL_START  = 8;

    // Confirmation bit positions
    localparam int WC_CMP_LO   = 0;
    localparam int WC_CMP_HI   = 1;
    localparam int WC_STEP     = 2;
    localparam int WC_CTRL     = 16;
    localparam int CWC_LO      = 0;
    localparam int CWC_HI      = 1;

    typedef enum logic [2:0] {
        TGT_CNT_LO = 3'd0,
        TGT_CNT_HI = 3'd1,
        TGT_CMP_LO = 3'd2,
        TGT_CMP_HI = 3'd3,
        TGT_STEP   = 3'd4,
        TGT_CTRL   = 3'd5
    } wr_tgt_e;

endpackage

// File: rtl/gcnt_sync_pipe.sv
// Fixed-latency delay line for register writes. Each accepted write comes
// out DEPTH clocks later, with its target and data unchanged.
// Assumes: at most one write enters per cycle; DEPTH >= 1.
module gcnt_sync_pipe
    import gcnt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  wr_tgt_e           in_tgt,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_vld,
    output wr_tgt_e           out_tgt,
    output logic [DATA_W-1:0] out_data
);

    logic              stg_vld  [DEPTH];
    wr_tgt_e           stg_tgt  [DEPTH];
    logic [DATA_W-1:0] stg_data [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_head
            // Capture an incoming write into the first stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_vld[k]  <= 1'b0;
                    stg_tgt[k]  <= TGT_CNT_LO;
                    stg_data[k] <= '0;
                end else begin
                    stg_vld[k]  <= in_vld;
                    stg_tgt[k]  <= in_tgt;
                    stg_data[k] <= in_data;
                end
            end
        end else begin : g_body
            // Shift the write one stage along the line
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_vld[k]  <= 1'b0;
                    stg_tgt[k]  <= TGT_CNT_LO;
                    stg_data[k] <= '0;
                end else begin
                    stg_vld[k]  <= stg_vld[k-1];
                    stg_tgt[k]  <= stg_tgt[k-1];
                    stg_data[k] <= stg_data[k-1];
                end
            end
        end
    end

    assign out_vld  = stg_vld[DEPTH-1];
    assign out_tgt  = stg_tgt[DEPTH-1];
    assign out_data = stg_data[DEPTH-1];

endmodule

// File: rtl/gcnt_counter.sv
// Free-running counter of two halves. A load of either half replaces that
// half only and takes priority over counting in that cycle.
// Assumes: ld_lo and ld_hi are never high together.
module gcnt_counter #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                ld_lo,
    input  logic                ld_hi,
    input  logic [HALF_W-1:0]   ld_data,
    output logic [2*HALF_W-1:0] cnt_o
);

    localparam int CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0] cnt_q;

    // Load a half, or advance by one while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_lo) begin
            cnt_q[HALF_W-1:0] <= ld_data;
        end else if (ld_hi) begin
            cnt_q[CNT_W-1:HALF_W] <= ld_data;
        end else if (run) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/gcnt_compare.sv
// Full-width comparator with step register and sticky match status.
// A match adds the step when auto is set; an explicit load wins over it.
// Assumes: at most one of the load strobes is high per cycle.
module gcnt_compare #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*HALF_W-1:0] cnt_i,
    input  logic                enable,
    input  logic                auto_inc,
    input  logic                ld_lo,
    input  logic                ld_hi,
    input  logic                ld_step,
    input  logic [HALF_W-1:0]   ld_data,
    input  logic                clr_stat,
    output logic [2*HALF_W-1:0] cmp_o,
    output logic [HALF_W-1:0]   step_o,
    output logic                match_o,
    output logic                stat_o
);

    localparam int CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0]  cmp_q;
    logic [HALF_W-1:0] step_q;
    logic              stat_q;
    logic              match;

    assign match = enable && (cnt_i == cmp_q);

    // Comparator value: explicit load, else advance by step on a match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (ld_lo) begin
            cmp_q[HALF_W-1:0] <= ld_data;
        end else if (ld_hi) begin
            cmp_q[CNT_W-1:HALF_W] <= ld_data;
        end else if (match && auto_inc) begin
            cmp_q <= cmp_q + {{HALF_W{1'b0}}, step_q};
        end
    end

    // Step register load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (ld_step) begin
            step_q <= ld_data;
        end
    end

    // Sticky match status; a match outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (match) begin
            stat_q <= 1'b1;
        end else if (clr_stat) begin
            stat_q <= 1'b0;
        end
    end

    assign cmp_o   = cmp_q;
    assign step_o  = step_q;
    assign match_o = match;
    assign stat_o  = stat_q;

endmodule

// File: rtl/gcnt_timer.sv
// Top of the global counter timer: register decode, the delayed-write
// path, control and enable registers, confirmation flags and read mux.
// Assumes: a simple single-cycle register bus, combinational reads.
module gcnt_timer
    import gcnt_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int HALF_W   = 32,
    parameter int SYNC_DLY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq_o
);

    localparam int CNT_W = 2 * HALF_W;
    localparam logic [HALF_W-1:0] CTRL_MASK =
        (HALF_W'(1) << CTRL_CMP_EN) | (HALF_W'(1) << CTRL_AUTO) |
        (HALF_W'(1) << CTRL_START);

    // Delayed-write decode
    logic    dly_vld;
    wr_tgt_e dly_tgt;

    // Route writes to delayed registers into the sync line
    always_comb begin
        dly_vld = 1'b0;
        dly_tgt = TGT_CNT_LO;
        if (bus_we) begin
            dly_vld = 1'b1;
            case (int'(bus_addr))
                OFF_CNT_LO: dly_tgt = TGT_CNT_LO;
                OFF_CNT_HI: dly_tgt = TGT_CNT_HI;
                OFF_CMP_LO: dly_tgt = TGT_CMP_LO;
                OFF_CMP_HI: dly_tgt = TGT_CMP_HI;
                OFF_STEP:   dly_tgt = TGT_STEP;
                OFF_CTRL:   dly_tgt = TGT_CTRL;
                default:    dly_vld = 1'b0;
            endcase
        end
    end

    logic              app_vld;
    wr_tgt_e           app_tgt;
    logic [HALF_W-1:0] app_data;

    gcnt_sync_pipe #(.DATA_W(HALF_W), .DEPTH(SYNC_DLY)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (dly_vld),
        .in_tgt   (dly_tgt),
        .in_data  (bus_wdata),
        .out_vld  (app_vld),
        .out_tgt  (app_tgt),
        .out_data (app_data)
    );

    logic cnt_ld_lo, cnt_ld_hi, cmp_ld_lo, cmp_ld_hi, step_ld, ctrl_ld;
    assign cnt_ld_lo = app_vld && (app_tgt == TGT_CNT_LO);
    assign cnt_ld_hi = app_vld && (app_tgt == TGT_CNT_HI);
    assign cmp_ld_lo = app_vld && (app_tgt == TGT_CMP_LO);
    assign cmp_ld_hi = app_vld && (app_tgt == TGT_CMP_HI);
    assign step_ld   = app_vld && (app_tgt == TGT_STEP);
    assign ctrl_ld   = app_vld && (app_tgt == TGT_CTRL);

    // Immediate-write strobes
    logic ien_wr, istat_wr, wconf_wr, cwconf_wr;
    assign ien_wr    = bus_we && (int'(bus_addr) == OFF_IEN);
    assign istat_wr  = bus_we && (int'(bus_addr) == OFF_ISTAT);
    assign wconf_wr  = bus_we && (int'(bus_addr) == OFF_WCONF);
    assign cwconf_wr = bus_we && (int'(bus_addr) == OFF_CWCONF);

    logic [HALF_W-1:0] ctrl_q;
    logic              ien_q;

    // Control register, landing after the sync delay
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_ld) begin
            ctrl_q <= app_data & CTRL_MASK;
        end
    end

    // Interrupt enable, written directly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
        end else if (ien_wr) begin
            ien_q <= bus_wdata[0];
        end
    end

    logic [CNT_W-1:0]  cnt_val;
    logic [CNT_W-1:0]  cmp_val;
    logic [HALF_W-1:0] step_val;
    logic              match;
    logic              istat_q;
    logic              stat_clr;

    assign stat_clr = istat_wr && bus_wdata[0];

    gcnt_counter #(.HALF_W(HALF_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q[CTRL_START]),
        .ld_lo   (cnt_ld_lo),
        .ld_hi   (cnt_ld_hi),
        .ld_data (app_data),
        .cnt_o   (cnt_val)
    );

    gcnt_compare #(.HALF_W(HALF_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_i    (cnt_val),
        .enable   (ctrl_q[CTRL_CMP_EN]),
        .auto_inc (ctrl_q[CTRL_AUTO]),
        .ld_lo    (cmp_ld_lo),
        .ld_hi    (cmp_ld_hi),
        .ld_step  (step_ld),
        .ld_data  (app_data),
        .clr_stat (stat_clr),
        .cmp_o    (cmp_val),
        .step_o   (step_val),
        .match_o  (match),
        .stat_o   (istat_q)
    );

    // Confirmation flags: set on landing, cleared by writing 1
    logic [HALF_W-1:0] wconf_q, cwconf_q, wconf_set, cwconf_set;

    // Build the set masks from the write that lands this cycle
    always_comb begin
        wconf_set  = '0;
        cwconf_set = '0;
        wconf_set[WC_CMP_LO] = cmp_ld_lo;
        wconf_set[WC_CMP_HI] = cmp_ld_hi;
        wconf_set[WC_STEP]   = step_ld;
        wconf_set[WC_CTRL]   = ctrl_ld;
        cwconf_set[CWC_LO]   = cnt_ld_lo;
        cwconf_set[CWC_HI]   = cnt_ld_hi;
    end

    // Update both confirmation registers; a set outranks a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wconf_q  <= '0;
            cwconf_q <= '0;
        end else begin
            wconf_q  <= (wconf_q  & ~(wconf_wr  ? bus_wdata : '0)) | wconf_set;
            cwconf_q <= (cwconf_q & ~(cwconf_wr ? bus_wdata : '0)) | cwconf_set;
        end
    end

    // Read multiplexer
    always_comb begin
        case (int'(bus_addr))
            OFF_CNT_LO: bus_rdata = cnt_val[HALF_W-1:0];
            OFF_CNT_HI: bus_rdata = cnt_val[CNT_W-1:HALF_W];
            OFF_CMP_LO: bus_rdata = cmp_val[HALF_W-1:0];
            OFF_CMP_HI: bus_rdata = cmp_val[CNT_W-1:HALF_W];
            OFF_STEP:   bus_rdata = step_val;
            OFF_CTRL:   bus_rdata = ctrl_q;
            OFF_IEN:    bus_rdata = {{(HALF_W-1){1'b0}}, ien_q};
            OFF_ISTAT:  bus_rdata = {{(HALF_W-1){1'b0}}, istat_q};
            OFF_WCONF:  bus_rdata = wconf_q;
            OFF_CWCONF: bus_rdata = cwconf_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_o = istat_q && ien_q;

endmodule

// File: rtl/gcnt_timer_chk.sv
// Property checker for the global counter timer, bound into the top.
// Assumes: connected to the top's internal counter and comparator nets.
module gcnt_timer_chk #(
    parameter int HALF_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                run,
    input logic                cmp_en,
    input logic                auto_inc,
    input logic                cnt_ld,
    input logic                cmp_ld,
    input logic [2*HALF_W-1:0] cnt_q,
    input logic [2*HALF_W-1:0] cmp_q,
    input logic [HALF_W-1:0]   step_q,
    input logic                match,
    input logic                stat_q,
    input logic                stat_clr,
    input logic                irq_o
);

    // R1: reset leaves counter, status and interrupt cleared
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0 && !stat_q && !irq_o));

    a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_ld) |=> $stable(cnt_q));

    a_r2_step_running: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_ld) |=> (cnt_q == $past(cnt_q) + 1'b1));

    a_r6_stat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !stat_clr) |=> stat_q);

    a_r8_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> stat_q);

    a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !match) |=> !stat_q);

    a_r9_auto_add: assert property (@(posedge clk) disable iff (!rst_n)
        (match && auto_inc && !cmp_ld) |=>
            (cmp_q == $past(cmp_q) + {{HALF_W{1'b0}}, $past(step_q)}));

    a_r10_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en && !stat_q) |=> !stat_q);

endmodule

bind gcnt_timer gcnt_timer_chk #(.HALF_W(HALF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_q[8]),
    .cmp_en   (ctrl_q[0]),
    .auto_inc (ctrl_q[1]),
    .cnt_ld   (cnt_ld_lo || cnt_ld_hi),
    .cmp_ld   (cmp_ld_lo || cmp_ld_hi),
    .cnt_q    (cnt_val),
    .cmp_q    (cmp_val),
    .step_q   (step_val),
    .match    (match),
    .stat_q   (istat_q),
    .stat_clr (stat_clr),
    .irq_o    (irq_o)
);

// File: tb/gcnt_timer_tb_top.sv
module gcnt_timer_tb_top;

    localparam logic [5:0] A_CLO = 6'h00, A_CHI = 6'h04, A_MLO = 6'h08,
                           A_MHI = 6'h0C, A_STP = 6'h10, A_CTL = 6'h14,
                           A_IEN = 6'h18, A_IST = 6'h1C, A_WC  = 6'h20,
                           A_CWC = 6'h24;
    localparam int WDOG = 50000;

    typedef struct packed {
        logic [5:0]  addr;
        logic [31:0] data;
        logic [5:0]  st_addr;
        logic [31:0] st_mask;
        logic [31:0] rb;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{A_CLO, 32'h1234_5678, A_CWC, 32'h0000_0001, 32'h1234_5678},
        '{A_CHI, 32'h9ABC_DEF0, A_CWC, 32'h0000_0002, 32'h9ABC_DEF0},
        '{A_MLO, 32'hAAAA_0001, A_WC,  32'h0000_0001, 32'hAAAA_0001},
        '{A_MHI, 32'h5555_0002, A_WC,  32'h0000_0002, 32'h5555_0002},
        '{A_STP, 32'h0000_0010, A_WC,  32'h0000_0004, 32'h0000_0010},
        '{A_CTL, 32'hFFFF_FEFE, A_WC,  32'h0001_0000, 32'h0000_0002}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gcnt_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG && !done) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, WDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic nwait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v, v2, lo, hi, cmp;
        string rq;
        bit found;

        // R1: reset state
        nwait(4);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a <= 'h24; a += 4) begin
            rd(6'(a), v);
            chk("R1", v, 32'h0);
        end
        chk("R1 irq", {31'h0, irq_o}, 32'h0);

        // R3/R4/R5: table of delayed writes
        foreach (VEC[i]) begin
            rq = (VEC[i].st_addr == A_CWC) ? "R3" : "R4";
            wr(VEC[i].addr, VEC[i].data);
            nwait(2);
            rd(VEC[i].st_addr, v);
            chk({rq, " early"}, v & VEC[i].st_mask, 32'h0);
            nwait(1);
            rd(VEC[i].st_addr, v);
            chk({rq, " conf"}, v & VEC[i].st_mask, VEC[i].st_mask);
            rd(VEC[i].addr, v);
            chk({rq, " value"}, v, VEC[i].rb);
            wr(VEC[i].st_addr, 32'h0);
            rd(VEC[i].st_addr, v);
            chk("R5 zero keeps", v & VEC[i].st_mask, VEC[i].st_mask);
            wr(VEC[i].st_addr, VEC[i].st_mask);
            rd(VEC[i].st_addr, v);
            chk("R5 clear", v & VEC[i].st_mask, 32'h0);
        end

        // R2: run then stop
        wr(A_CTL, 32'h100);
        nwait(4);
        rd(A_CLO, v);
        @(negedge clk);
        rd(A_CLO, v2);
        chk("R2 run", v2, v + 32'd1);
        rd(A_CHI, v);
        chk("R11 hi independent", v, 32'h9ABC_DEF0);
        wr(A_CTL, 32'h0);
        nwait(4);
        rd(A_CLO, v);
        @(negedge clk);
        rd(A_CLO, v2);
        chk("R2 hold", v2, v);

        // R11: carry from low to high half
        wr(A_CLO, 32'hFFFF_FFFC);
        wr(A_CHI, 32'h0);
        nwait(4);
        wr(A_CTL, 32'h100);
        nwait(14);
        wr(A_CTL, 32'h0);
        nwait(4);
        rd(A_CHI, hi);
        rd(A_CLO, lo);
        chk("R11 carry hi", hi, 32'h1);
        chk("R11 carry lo small", {31'h0, lo < 32'h40}, 32'h1);

        // R10/R12/R6/R7/R8 against a stopped counter
        wr(A_MLO, lo);
        wr(A_MHI, hi);
        nwait(4);
        rd(A_IST, v);
        chk("R10 disabled", v, 32'h0);
        wr(A_MHI, hi + 32'd1);
        nwait(4);
        wr(A_CTL, 32'h1);
        nwait(4);
        rd(A_IST, v);
        chk("R12 high differs", v, 32'h0);
        wr(A_MHI, hi);
        nwait(4);
        rd(A_IST, v);
        chk("R6 match", v, 32'h1);
        nwait(3);
        rd(A_IST, v);
        chk("R6 sticky", v, 32'h1);
        chk("R7 masked", {31'h0, irq_o}, 32'h0);
        wr(A_IEN, 32'h1);
        chk("R7 raised", {31'h0, irq_o}, 32'h1);
        wr(A_IST, 32'h1);
        rd(A_IST, v);
        chk("R8 match wins", v, 32'h1);
        wr(A_CTL, 32'h0);
        nwait(4);
        wr(A_IST, 32'h1);
        rd(A_IST, v);
        chk("R8 cleared", v, 32'h0);
        chk("R7 dropped", {31'h0, irq_o}, 32'h0);
        wr(A_IEN, 32'h0);

        // R9: periodic matches with step 7
        wr(A_CLO, 32'd0);
        wr(A_CHI, 32'd0);
        wr(A_MLO, 32'd20);
        wr(A_MHI, 32'd0);
        wr(A_STP, 32'd7);
        nwait(4);
        wr(A_CTL, 32'h103);
        found = 0;
        for (int i = 0; i < 200 && !found; i++) begin
            @(negedge clk);
            rd(A_IST, v);
            if (v[0]) found = 1;
        end
        chk("R9 first match", {31'h0, found}, 32'h1);
        rd(A_MLO, v);
        chk("R9 cmp advanced", v, 32'd27);
        rd(A_CLO, v);
        chk("R9 cnt at match", v, 32'd21);
        nwait(30);
        wr(A_CTL, 32'h3);
        nwait(4);
        rd(A_CLO, lo);
        rd(A_MLO, cmp);
        chk("R9 cmp formula", cmp, 32'd20 + 32'd7 * ((lo - 32'd20) / 32'd7 + 32'd1));
        rd(A_MHI, v);
        chk("R9 cmp hi", v, 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule